// File: doc/BRIEF.md
# Pipelined Shift-Add Lowpass FIR Filter

This block is a constant-coefficient lowpass FIR filter that accepts one signed fixed-point sample on every clock where the enable is high and delivers one filtered sample at the same rate. It has no general multipliers. Each coefficient is recoded at elaboration time into canonic signed digit (CSD) form, and its product is built from shifted copies of the data that are added or subtracted, one for each nonzero digit. The coefficient set is symmetric, so taps that mirror each other are summed before the product network, and each coefficient network is used only once.

The products go into a binary tree of pairwise adders with a register after every level. The tree root is narrowed to the output width by flooring, clamped to the output range, and held in an output register. There is no input register. The tap count and the coefficient values are parameters, and the pipeline depth follows from the tap count. With the default 31 taps the latency is 8 enabled samples.

Top module: `fir_csd_top`

## Requirements
- R1: While `rst_ni` is low, and after its release until data arrives, `y_o` is 0.
- R2: For an input history x[n], y_o equals sat(floor(sum over k of h[k]*x[n-k] / 2^COEF_FRAC)). Both x_i and y_o are two's complement with 15 fraction bits, the coefficients have COEF_FRAC fraction bits, and the sum is carried in ACC_W = 40 bits.
- R3: A sample presented before enabled edge m first affects y_o just after enabled edge m+L-1. L = 4 + ceil(log2(ceil(N_TAPS/2))), which gives 8 for the default 31 taps.
- R4: The full response uses h[k] = h[N_TAPS-1-k], taken from the half-set parameter `COEF_HALF` (entry k for k < ceil(N_TAPS/2)). With an odd tap count the centre tap stands alone.
- R5: Narrowing rounds toward minus infinity, so a small negative exact result gives -1 and not 0.
- R6: A result above 32767 saturates to 32767.
- R7: A result below -32768 saturates to -32768.
- R8: On a clock where `en_i` is low, no register moves: y_o holds its value and x_i is ignored.
- R9: When the count of leaves in the adder tree is not a power of two, the unpaired operands pass through registers, so every product has the same latency.
- R10: After N_TAPS+L-1 consecutive enabled zero samples, y_o is 0.
- R11: Coefficient values at the ends of the range (32767, -32768, -1, 1, 0) give exact products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Sample enable; the pipeline advances only when high |
| x_i | input | IN_W (16) | Signed input sample with 15 fraction bits |
| y_o | output | OUT_W (16) | Registered, floored and saturated filter output |

## Verification
The bench builds two instances. The first uses the default 31-tap lowpass set, which has 16 tree leaves and a latency of 8. The second uses 11 taps whose half-set is {32767, -32768, 21845, -1, 1, 0}. This gives 6 leaves, so the tree has pass-through registers and a latency of 7. Its large gain lets full-scale alternating input drive the output into both saturation limits. The extreme coefficients exercise CSD recodings with long runs of digits, and the leading -1 and 1 entries expose flooring on small negative results.

// File: rtl/fir_pkg.sv
`timescale 1ns/1ps
package fir_pkg;
  localparam int DEF_N_TAPS = 31;
  localparam int DEF_HALF   = (DEF_N_TAPS + 1) / 2;

  // half of a symmetric lowpass set, last entry is the centre tap (Q0.16)
  localparam logic signed [15:0] DEF_COEF_HALF [DEF_HALF] = '{
    -16'sd14,   -16'sd42,   16'sd31,    16'sd113,
     16'sd22,   -16'sd238,  -16'sd170,  16'sd356,
     16'sd460,  -16'sd390,  -16'sd1010, 16'sd205,
     16'sd1980,  16'sd522,  -16'sd4370, 16'sd26214
  };

  // CSD digit masks: neg=0 returns +1 digits, neg=1 returns -1 digits
  function automatic logic [63:0] csd_mask(input longint coef, input bit neg);
    longint c;
    longint d;
    logic [63:0] m;
    c = coef;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (c[0]) begin
        d = 2 - (c & 3);
        if (neg ? (d < 0) : (d > 0)) m[i] = 1'b1;
        c = c - d;
      end
      c = c >>> 1;
    end
    return m;
  endfunction

  // lowest leaf index under a heap node of a tree with pow2 leaves
  function automatic int first_leaf(input int node, input int pow2);
    int n;
    n = node;
    while (n < pow2 - 1) n = 2 * n + 1;
    return n - (pow2 - 1);
  endfunction

  function automatic int fir_latency(input int n_taps);
    return 4 + $clog2((n_taps + 1) / 2);
  endfunction
endpackage

// File: rtl/fir_csd_mul.sv
`timescale 1ns/1ps
module fir_csd_mul #(
  parameter int     IN_W   = 17,
  parameter int     ACC_W  = 40,
  parameter int     COEF_W = 16,
  parameter longint COEF   = 0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [IN_W-1:0]  a_i,
  output logic signed [ACC_W-1:0] p_o
);
  localparam int NDIG  = COEF_W + 1;
  localparam int SPLIT = NDIG / 2;
  localparam logic [NDIG-1:0] POS = NDIG'(fir_pkg::csd_mask(COEF, 1'b0));
  localparam logic [NDIG-1:0] NEG = NDIG'(fir_pkg::csd_mask(COEF, 1'b1));

  logic signed [ACC_W-1:0] ext, lo_d, hi_d, lo_q, hi_q, p_q;

  assign ext = {{(ACC_W-IN_W){a_i[IN_W-1]}}, a_i};

  // digit terms split into two groups, one register stage between groups and final add
  always_comb begin
    lo_d = '0;
    hi_d = '0;
    for (int i = 0; i < NDIG; i++) begin
      if (i < SPLIT) begin
        if (POS[i]) lo_d = lo_d + (ext <<< i);
        if (NEG[i]) lo_d = lo_d - (ext <<< i);
      end else begin
        if (POS[i]) hi_d = hi_d + (ext <<< i);
        if (NEG[i]) hi_d = hi_d - (ext <<< i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
      p_q  <= '0;
    end else if (en_i) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
      p_q  <= lo_q + hi_q;
    end
  end

  assign p_o = p_q;
endmodule

// File: rtl/fir_add_tree.sv
`timescale 1ns/1ps
module fir_add_tree #(
  parameter int N_IN = 16,
  parameter int W    = 40
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic [N_IN-1:0][W-1:0]     leaf_i,
  output logic signed [W-1:0]        sum_o
);
  localparam int LVLS  = $clog2(N_IN);
  localparam int P     = 1 << LVLS;
  localparam int NODES = 2 * P - 1;

  // heap layout: node i has children 2i+1, 2i+2; leaves at P-1..2P-2
  // empty subtrees are not built; a node with an empty right side registers its left child
  for (genvar i = 0; i < NODES; i++) begin : g_node
    if (i >= P - 1 && (i - (P - 1)) < N_IN) begin : g_b
      logic signed [W-1:0] q;
      assign q = $signed(leaf_i[i-(P-1)]);
    end else if (i < P - 1 && fir_pkg::first_leaf(2*i+1, P) < N_IN) begin : g_b
      logic signed [W-1:0] q;
      if (fir_pkg::first_leaf(2*i+2, P) >= N_IN) begin : g_pass
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)   q <= '0;
          else if (en_i) q <= g_node[2*i+1].g_b.q;
        end
      end else begin : g_add
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)   q <= '0;
          else if (en_i) q <= g_node[2*i+1].g_b.q + g_node[2*i+2].g_b.q;
        end
      end
    end
  end

  assign sum_o = g_node[0].g_b.q;
endmodule

// File: rtl/fir_csd_top.sv
`timescale 1ns/1ps
module fir_csd_top #(
  parameter int N_TAPS    = fir_pkg::DEF_N_TAPS,
  parameter int IN_W      = 16,
  parameter int OUT_W     = 16,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 16,
  parameter int ACC_W     = 40,
  parameter logic signed [COEF_W-1:0] COEF_HALF [(N_TAPS+1)/2] = fir_pkg::DEF_COEF_HALF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [IN_W-1:0]  x_i,
  output logic signed [OUT_W-1:0] y_o
);
  localparam int HALF = (N_TAPS + 1) / 2;
  localparam int LAT  = fir_pkg::fir_latency(N_TAPS);
  localparam logic signed [ACC_W-1:0] SAT_HI = $signed(ACC_W'((longint'(1) <<< (OUT_W-1)) - 1));
  localparam logic signed [ACC_W-1:0] SAT_LO = $signed(ACC_W'(-(longint'(1) <<< (OUT_W-1))));

  logic signed [IN_W-1:0]  dly_q [N_TAPS-1];
  logic signed [IN_W-1:0]  tap_w [N_TAPS];
  logic [HALF-1:0][ACC_W-1:0] prod_w;
  logic signed [ACC_W-1:0] acc_w, sh_w;
  logic signed [OUT_W-1:0] y_d, y_q;

  // tap delay line; tap 0 is the live input (no input register)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_TAPS-1; i++) dly_q[i] <= '0;
    end else if (en_i) begin
      dly_q[0] <= x_i;
      for (int i = 1; i < N_TAPS-1; i++) dly_q[i] <= dly_q[i-1];
    end
  end

  always_comb begin
    tap_w[0] = x_i;
    for (int i = 1; i < N_TAPS; i++) tap_w[i] = dly_q[i-1];
  end

  // fold mirrored taps, then one CSD network per distinct coefficient
  for (genvar j = 0; j < HALF; j++) begin : g_tap
    localparam int MIRR = N_TAPS - 1 - j;
    logic signed [IN_W:0] pre_q;
    if (MIRR != j) begin : g_pair
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   pre_q <= '0;
        else if (en_i) pre_q <= {tap_w[j][IN_W-1], tap_w[j]} + {tap_w[MIRR][IN_W-1], tap_w[MIRR]};
      end
    end else begin : g_centre
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   pre_q <= '0;
        else if (en_i) pre_q <= {tap_w[j][IN_W-1], tap_w[j]};
      end
    end

    fir_csd_mul #(
      .IN_W  (IN_W + 1),
      .ACC_W (ACC_W),
      .COEF_W(COEF_W),
      .COEF  (longint'(COEF_HALF[j]))
    ) u_mul (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_i),
      .a_i   (pre_q),
      .p_o   (prod_w[j])
    );
  end

  fir_add_tree #(
    .N_IN(HALF),
    .W   (ACC_W)
  ) u_tree (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .leaf_i(prod_w),
    .sum_o (acc_w)
  );

  // floor by arithmetic shift, then clamp
  always_comb begin
    sh_w = acc_w >>> COEF_FRAC;
    if (sh_w > SAT_HI)      y_d = SAT_HI[OUT_W-1:0];
    else if (sh_w < SAT_LO) y_d = SAT_LO[OUT_W-1:0];
    else                    y_d = sh_w[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   y_q <= '0;
    else if (en_i) y_q <= y_d;
  end

  assign y_o = y_q;
endmodule

// File: rtl/fir_csd_chk.sv
`timescale 1ns/1ps
module fir_csd_chk #(
  parameter int N_TAPS    = 31,
  parameter int IN_W      = 16,
  parameter int OUT_W     = 16,
  parameter int ACC_W     = 40,
  parameter int COEF_FRAC = 16,
  parameter int LAT       = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    en_i,
  input logic signed [IN_W-1:0]  x_i,
  input logic signed [ACC_W-1:0] acc_i,
  input logic signed [OUT_W-1:0] y_i
);
  localparam int RUN_MIN = N_TAPS + LAT - 1;
  localparam int RW      = $clog2(RUN_MIN + 1) + 1;
  localparam logic signed [OUT_W-1:0] Y_HI = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] Y_LO = {1'b1, {(OUT_W-1){1'b0}}};

  logic [RW-1:0] zrun_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) zrun_q <= '0;
    else if (en_i) begin
      if (x_i != '0)                zrun_q <= '0;
      else if (zrun_q < RW'(RUN_MIN)) zrun_q <= zrun_q + 1'b1;
    end
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> y_i == '0);

  // R8
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(y_i));

  // R6
  sat_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ((acc_i >>> COEF_FRAC) > ACC_W'(Y_HI))) |=> y_i == Y_HI);

  // R7
  sat_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ((acc_i >>> COEF_FRAC) < ACC_W'(Y_LO))) |=> y_i == Y_LO);

  // R10
  zero_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zrun_q >= RW'(RUN_MIN)) |-> y_i == '0);
endmodule

bind fir_csd_top fir_csd_chk #(
  .N_TAPS   (N_TAPS),
  .IN_W     (IN_W),
  .OUT_W    (OUT_W),
  .ACC_W    (ACC_W),
  .COEF_FRAC(COEF_FRAC),
  .LAT      (LAT)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en_i  (en_i),
  .x_i   (x_i),
  .acc_i (acc_w),
  .y_i   (y_o)
);

// File: tb/sim_fir_csd_top.sv
`timescale 1ns/1ps
module sim_fir_csd_top;
  localparam int N0 = 31, H0 = 16, N1 = 11, H1 = 6, CF = 16;
  localparam int LAT0 = 4 + $clog2(H0);
  localparam int LAT1 = 4 + $clog2(H1);
  localparam logic signed [15:0] C0 [H0] = '{
    -16'sd14,   -16'sd42,   16'sd31,    16'sd113,
     16'sd22,   -16'sd238,  -16'sd170,  16'sd356,
     16'sd460,  -16'sd390,  -16'sd1010, 16'sd205,
     16'sd1980,  16'sd522,  -16'sd4370, 16'sd26214
  };
  localparam logic signed [15:0] C1 [H1] = '{
    16'sd32767, 16'h8000, 16'sd21845, -16'sd1, 16'sd1, 16'sd0
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0;
  logic signed [15:0] x = '0;
  logic signed [15:0] y0, y1;

  always #2.5 clk = ~clk;

  fir_csd_top #(.N_TAPS(N0), .COEF_HALF(C0)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .x_i(x), .y_o(y0));
  fir_csd_top #(.N_TAPS(N1), .COEF_HALF(C1)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .x_i(x), .y_o(y1));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string tag = "R1";
  int hf0[], hf1[];
  int hist0[$], hist1[$], q0[$], q1[$];
  int last0 = 0, last1 = 0;
  int lfsr = 16'hACE1;

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int ref_y(input int hf[], input int hist[$]);
    longint acc = 0;
    for (int k = 0; k < hf.size(); k++) acc += longint'(hf[k]) * longint'(hist[k]);
    acc = acc >>> CF;
    if (acc > 32767)  return 32767;
    if (acc < -32768) return -32768;
    return int'(acc);
  endfunction

  function automatic int next_rand();
    lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
    return lfsr - 32768;
  endfunction

  // drive at negedge, compare just after the next rising edge
  task automatic cyc(input int xv, input bit ev);
    @(negedge clk);
    x  = 16'(xv);
    en = ev;
    @(posedge clk);
    #1;
    if (ev) begin
      hist0.push_front(xv); void'(hist0.pop_back());
      hist1.push_front(xv); void'(hist1.pop_back());
      q0.push_back(ref_y(hf0, hist0)); last0 = q0.pop_front();
      q1.push_back(ref_y(hf1, hist1)); last1 = q1.pop_front();
    end
    chk({tag, " u0"}, int'(y0), last0);
    chk({tag, " u1"}, int'(y1), last1);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int rec0[$], rec1[$];
    int first0, first1, nhi, nlo;
    hf0 = new[N0];
    hf1 = new[N1];
    for (int k = 0; k < N0; k++) hf0[k] = int'(C0[(k < N0-1-k) ? k : N0-1-k]);
    for (int k = 0; k < N1; k++) hf1[k] = int'(C1[(k < N1-1-k) ? k : N1-1-k]);
    for (int k = 0; k < N0; k++) hist0.push_back(0);
    for (int k = 0; k < N1; k++) hist1.push_back(0);
    for (int k = 0; k < LAT0-1; k++) q0.push_back(0);
    for (int k = 0; k < LAT1-1; k++) q1.push_back(0);

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 u0 in reset", int'(y0), 0);
    chk("R1 u1 in reset", int'(y1), 0);
    rst_ni = 1'b1;
    tag = "R1";
    for (int i = 0; i < 4; i++) cyc(0, 1);

    // R3 R9: impulse latency, R4: symmetric response
    tag = "R3";
    first0 = -1; first1 = -1;
    for (int i = 0; i < 50; i++) begin
      cyc((i == 0) ? 16384 : 0, 1);
      rec0.push_back(int'(y0));
      rec1.push_back(int'(y1));
      if (first0 < 0 && y0 != 0) first0 = i;
      if (first1 < 0 && y1 != 0) first1 = i;
    end
    chk("R3 latency u0", first0, LAT0 - 1);
    chk("R3 R9 latency u1", first1, LAT1 - 1);
    for (int k = 0; k < N0/2; k++)
      chk("R4 symmetry u0", rec0[LAT0-1+k], rec0[LAT0-1+N0-1-k]);
    for (int k = 0; k < N1/2; k++)
      chk("R4 symmetry u1", rec1[LAT1-1+k], rec1[LAT1-1+N1-1-k]);

    // R2: step
    tag = "R2 step";
    for (int i = 0; i < 45; i++) cyc(20000, 1);

    // R5: tiny negative impulse floors to -1 on positive taps
    tag = "R5";
    for (int i = 0; i < 45; i++) cyc(0, 1);
    rec0.delete();
    for (int i = 0; i < 45; i++) begin
      cyc((i == 0) ? -1 : 0, 1);
      rec0.push_back(int'(y0));
    end
    chk("R5 floor tap2 u0", rec0[LAT0-1+2], -1);
    chk("R5 floor tap0 u0", rec0[LAT0-1], 0);

    // R2: ramp
    tag = "R2 ramp";
    for (int i = 0; i < 40; i++) cyc(-30000 + 1500 * i, 1);

    // R6 R7: full-scale alternating input
    tag = "R6 R7";
    nhi = 0; nlo = 0;
    for (int i = 0; i < 60; i++) begin
      cyc((i % 2) ? 32767 : -32768, 1);
      if (y1 == 16'sd32767) nhi++;
      if (y1 == -16'sd32768) nlo++;
    end
    chk("R6 high clamp seen u1", int'(nhi > 0), 1);
    chk("R7 low clamp seen u1", int'(nlo > 0), 1);

    // R8: enable gaps with changing input
    tag = "R8";
    for (int i = 0; i < 90; i++) cyc(next_rand(), (i % 3) != 1);

    // R2 R11: pseudo-random full-range data
    tag = "R2 R11";
    for (int i = 0; i < 300; i++) cyc(next_rand(), 1);

    // R10: zero flush
    tag = "R10";
    for (int i = 0; i < N0 + LAT0; i++) cyc(0, 1);
    chk("R10 flushed u0", int'(y0), 0);
    chk("R10 flushed u1", int'(y1), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule